// File: doc/BRIEF.md
# Real-Time Clock Timebase with Sticky Interrupt Flags

This block divides its input clock by a programmable 20-bit amount to produce a periodic time-base tick. Each tick advances a tick counter and raises a sticky second flag. The counter can raise an alarm flag when it reaches a value on the `alarm_val` input. It raises an overflow flag when it wraps. Each committed register write raises a synchronisation flag. Every flag has its own enable bit, and the block ORs the enabled flags into a single interrupt output.

Software reaches the block through a simple register port with a combinational read path. The divider reload value is split across two 16-bit registers. The control register, both reload registers and the counter register are protected. An accepted write to any of them makes the block busy for a fixed number of cycles, which models the time needed to absorb the write into the slow domain. While the block is busy, a status bit reads 0 and further protected writes are dropped. The written value takes effect when the busy window ends.

Top module: `rtc_timebase`

## Requirements
- R1: After reset the enable register reads 0, the flag register reads 0x0020 (write-ready set, no flags), the counter reads 0, `tick` and `irq` are 0.
- R2: An accepted write to a protected register (0=enables, 2=reload high, 3=reload low, 4=counter) clears the write-ready bit (flag register bit 5) for exactly 3 cycles. The written value takes effect when the bit returns to 1.
- R3: A write to a protected register while write-ready is 0 has no effect.
- R4: The reload value is {reload-high bits 3:0, reload-low bits 15:0}. Upper bits of the reload-high data are discarded, and both reload addresses read as 0.
- R5: With a nonzero reload value R, `tick` pulses for one cycle every R+1 cycles. When a reload write takes effect, the prescaler restarts so that the first tick comes R cycles later. While the reload value is 0, no ticks occur.
- R6: Each tick sets the second flag (flag bit 0).
- R7: Each tick increments the counter at address 4. A tick that wraps it from all ones to zero sets the overflow flag (bit 2).
- R8: A tick that moves the counter to a value equal to `alarm_val` sets the alarm flag (bit 1).
- R9: When a protected write takes effect, the synchronisation flag (bit 3) is set.
- R10: Writing the flag register (address 1) clears each flag whose data bit is 0 and leaves unchanged any flag whose data bit is 1. A set event in the same cycle as a clear leaves the flag set.
- R11: `irq` is 1 exactly when some flag and its enable (the same bit position in register 0) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| alarm_val | input | CNT_W | Counter value that raises the alarm flag |
| tick | output | 1 | One-cycle time-base pulse |
| irq | output | 1 | OR of enabled flags |

## Verification
The bench measures the delay from a reload commit to the first tick, both with a reload value that needs the high register and with a small one. A design that ignored the high nibble, or that did not restart the prescaler on commit, would give the wrong count. It attempts a control write inside the busy window. A design that accepted it would read back the second value. It clears the second flag in the very cycle a tick sets it, which catches a design that lets a clear beat a set. It also steps the counter across the wrap and onto the alarm value, one tick at a time, so that a flag raised one tick early or late is seen.

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
  parameter int PRESC_W = 20,
  parameter int CNT_W   = 16,
  parameter int WR_LAT  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [15:0]      wdata,
  output logic [15:0]      rdata,
  input  logic [CNT_W-1:0] alarm_val,
  output logic             tick,
  output logic             irq
);
  localparam int HI_W  = PRESC_W - 16;
  localparam int LAT_W = $clog2(WR_LAT + 1);
  localparam logic [2:0] A_IE = 3'd0, A_FLG = 3'd1, A_RHI = 3'd2, A_RLO = 3'd3, A_CNT = 3'd4;

  logic [3:0]         ie, flag, flag_set, flag_clr;
  logic [HI_W-1:0]    rld_hi;
  logic [15:0]        rld_lo, pend_data, cnt_rd;
  logic [2:0]         pend_addr;
  logic [LAT_W-1:0]   busy;
  logic [PRESC_W-1:0] presc, reload, new_reload;
  logic [CNT_W-1:0]   cnt, cnt_next;

  wire ready    = busy == '0;
  wire prot     = addr == A_IE || addr == A_RHI || addr == A_RLO || addr == A_CNT;
  wire accept   = wr_en && prot && ready;
  wire commit   = busy == LAT_W'(1);
  wire com_hi   = commit && pend_addr == A_RHI;
  wire com_lo   = commit && pend_addr == A_RLO;
  wire com_rld  = com_hi || com_lo;
  wire com_cnt  = commit && pend_addr == A_CNT;

  assign reload     = {rld_hi, rld_lo};
  assign new_reload = com_hi ? {pend_data[HI_W-1:0], rld_lo} : {rld_hi, pend_data};
  assign tick       = reload != '0 && presc == '0;
  assign cnt_next   = cnt + 1'b1;
  assign cnt_rd     = 16'(cnt);

  assign flag_set = {commit,
                     tick && !com_cnt && (&cnt),
                     tick && !com_cnt && cnt_next == alarm_val,
                     tick};
  assign flag_clr = (wr_en && addr == A_FLG) ? ~wdata[3:0] : 4'b0;
  assign irq      = |(flag & ie);

  always_comb begin
    case (addr)
      A_IE:    rdata = {12'b0, ie};
      A_FLG:   rdata = {10'b0, ready, 1'b0, flag};
      A_CNT:   rdata = cnt_rd;
      default: rdata = 16'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= '0;
      pend_addr <= '0;
      pend_data <= '0;
    end else if (accept) begin
      busy      <= LAT_W'(WR_LAT);
      pend_addr <= addr;
      pend_data <= wdata;
    end else if (!ready) begin
      busy <= busy - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie     <= '0;
      rld_hi <= '0;
      rld_lo <= '0;
    end else begin
      if (commit && pend_addr == A_IE) ie <= pend_data[3:0];
      if (com_hi) rld_hi <= pend_data[HI_W-1:0];
      if (com_lo) rld_lo <= pend_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              presc <= '0;
    else if (com_rld)        presc <= new_reload;
    else if (reload != '0)   presc <= (presc == '0) ? reload : presc - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (com_cnt) cnt <= pend_data[CNT_W-1:0];
    else if (tick)    cnt <= cnt_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag <= '0;
    else        flag <= (flag & ~flag_clr) | flag_set;
  end

  assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);
  assert_busy_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy <= LAT_W'(WR_LAT));
  assert_ignored_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && prot && !ready) |=> $stable(pend_data) && $stable(pend_addr));
  assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !com_rld) |=> !tick);
  assert_tick_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> flag[0]);
  assert_alarm_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag[1] && ie[1]) |-> irq);

  for (genvar i = 0; i < 4; i++) begin : g_sticky
    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag[i]) |-> $past(wr_en && addr == A_FLG && !wdata[i]));
  end
endmodule

// File: tb/rtc_timebase_bench.sv
module rtc_timebase_bench;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0]  addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic [15:0] alarm_val = 16'h8000;
  logic        tick, irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_timebase u_rtc_timebase (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .alarm_val(alarm_val), .tick(tick), .irq(irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_ready();
    logic [15:0] v;
    for (int i = 0; i < 20; i++) begin
      peek(3'd1, v);
      if (v[5]) return;
      @(negedge clk);
    end
  endtask

  task automatic wait_tick();
    while (1) begin
      #1;
      if (tick) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    peek(3'd0, v); check("R1 enables", v, 16'h0);
    peek(3'd1, v); check("R1 flags", v, 16'h0020);
    peek(3'd4, v); check("R1 counter", v, 16'h0);
    check("R1 tick/irq", {tick, irq}, 2'b00);
    wr(3'd1, 16'h002F);
    peek(3'd1, v); check("R10 write ones no effect", v, 16'h0020);
  endtask

  task automatic t_busy();
    logic [15:0] v;
    wr(3'd0, 16'h0000);
    peek(3'd1, v); check("R2 busy c1", v[5], 0);
    @(negedge clk); peek(3'd1, v); check("R2 busy c2", v[5], 0);
    @(negedge clk); peek(3'd1, v); check("R2 busy c3", v[5], 0);
    @(negedge clk); peek(3'd1, v); check("R2 ready c4", v[5], 1);
    check("R9 sync flag", v[3], 1);
    wr(3'd1, 16'h0007);
    peek(3'd1, v); check("R10 sync cleared", v[3:0], 4'h0);
  endtask

  task automatic t_ignore();
    logic [15:0] v;
    wr(3'd0, 16'h000C);
    wr(3'd0, 16'h0003);
    wait_ready();
    peek(3'd0, v); check("R3 busy write dropped", v, 16'h000C);
    wr(3'd0, 16'h0000); wait_ready();
    wr(3'd1, 16'h0000);
  endtask

  task automatic t_reload();
    logic [15:0] v;
    int n;
    peek(3'd2, v); check("R4 reload high reads 0", v, 0);
    wr(3'd2, 16'hFFF1); wait_ready();
    wr(3'd3, 16'h0000); wait_ready();
    n = 0;
    while (1) begin #1; if (tick) break; @(negedge clk); n++; end
    check("R4/R5 high nibble delay", n, 32'h10000);
    @(negedge clk);
    peek(3'd4, v); check("R7 count after tick", v, 16'h1);
    peek(3'd1, v); check("R6 second flag", v[0], 1);
    wr(3'd2, 16'h0000); wait_ready();
    peek(3'd4, v);
    repeat (10) @(negedge clk);
    peek(3'd4, n); check("R5 zero reload no ticks", n, v);
    wr(3'd3, 16'h0004); wait_ready();
    n = 0;
    while (1) begin #1; if (tick) break; @(negedge clk); n++; end
    check("R5 first tick delay", n, 4);
    @(negedge clk); n = 1;
    while (1) begin #1; if (tick) break; @(negedge clk); n++; end
    check("R5 period", n, 5);
    @(negedge clk);
  endtask

  task automatic t_wrap_alarm();
    logic [15:0] v;
    wr(3'd4, 16'hFFFE); wait_ready();
    peek(3'd4, v); check("R2 counter committed", v, 16'hFFFE);
    wr(3'd1, 16'h0000);
    wait_tick();
    peek(3'd1, v); check("R7 no overflow at FFFF", v[2], 0);
    wait_tick();
    peek(3'd4, v); check("R7 wrapped", v, 16'h0);
    peek(3'd1, v); check("R7 overflow flag", v[2], 1);
    alarm_val = 16'h0002;
    wr(3'd1, 16'h0000);
    wait_tick();
    peek(3'd1, v); check("R8 no alarm at 1", v[1], 0);
    wait_tick();
    peek(3'd4, v); check("R8 count 2", v, 16'h2);
    peek(3'd1, v); check("R8 alarm flag", v[1], 1);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    wr(3'd0, 16'h0002); wait_ready(); #1;
    check("R11 alarm irq", irq, 1);
    wr(3'd1, 16'h000D); #1;
    check("R11 irq after alarm clear", irq, 0);
    wr(3'd0, 16'h0001); wait_ready(); #1;
    check("R11 second irq", irq, 1);
  endtask

  task automatic t_set_wins();
    logic [15:0] v;
    while (1) begin #1; if (tick) break; @(negedge clk); end
    wr_en = 1; addr = 3'd1; wdata = 16'h0000;
    @(negedge clk); wr_en = 0;
    peek(3'd1, v); check("R10 set beats clear", v[0], 1);
    wr(3'd1, 16'h0000);
    peek(3'd1, v); check("R10 clear by zero", v[0], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_busy();
    t_ignore();
    t_reload();
    t_wrap_alarm();
    t_irq();
    t_set_wins();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule